// File: doc/BRIEF.md
# Touch-Panel Converter Serial Sequencer

This block is the digital heart of a resistive touch-panel converter seen from the device side. A single serial clock both moves bits on the wire and paces the successive-approximation conversion. The block sits idle watching the serial input for a high start bit. It then collects the rest of an eight-bit command, which holds a three-bit input selector, a resolution flag, a reference-mode flag and two power-management bits. It tracks the analog input for three clocks and flags the hold instant with a one-clock busy pulse. It then resolves the sample one bit per clock against an external comparator. Each decided bit goes out on the serial output at once, most significant bit first.

While chip select stays low, the host can send the next command before the current result has finished shifting out. This gives frame lengths of 24, 16 or 15 clocks in 12-bit mode and down to 11 clocks in 8-bit mode. A rule tied to the resolution of the command just received sets the earliest clock at which a new start bit counts. Raising chip select floats both outputs and abandons any command or conversion in flight. The analog switch matrix, capacitor array and comparator lie outside the block. The block only presents a trial code and reads back one comparator bit, which is high when the input is at or above the trial code.

Top module: `tsc_seq`

## Requirements
- R1: While idle with chip select low, a 0 sampled on the serial input on a rising clock edge starts nothing. A 1 sampled this way is taken as the start bit of clock 1 of a frame.
- R2: The seven bits after the start bit are sampled on the next seven rising edges, most significant first, in this order: selector[2:0], resolution flag (1 = 8-bit), reference flag (1 = single-ended), power bits[1:0]. The selector, reference and power outputs change on the rising edge of clock 8 and not before.
- R3: The track output rises on the falling edge of clock 5 and falls on the falling edge of clock 8, so it is high for three clocks.
- R4: Busy is high from the falling edge of clock 8 to the falling edge of clock 9, exactly one clock.
- R5: The serial output changes on falling edges only. It carries the result bits from the falling edge of clock 9 onward, most significant first, one bit per clock, and is 0 at all other times, including while a command is being received.
- R6: A 12-bit conversion returns the largest code whose trial got a high comparator answer, in straight binary. For an ideal comparator this code equals the input.
- R7: With the resolution flag set, only eight bits are resolved. The last one leaves on the falling edge of clock 16, and the result is the top eight bits of the 12-bit answer, right-aligned.
- R8: After a complete command, start bits are ignored until the rising edge of clock 16 in 12-bit mode or clock 12 in 8-bit mode. A 1 at or after that edge starts a new frame even while the previous result is still shifting out.
- R9: While chip select is high, both output enables are 0, the serial input is ignored, and any command or conversion in flight is abandoned without a done strobe.
- R10: A command cut short by chip select leaves the selector, reference and power outputs unchanged.
- R11: Every finished conversion raises done for exactly one clock, on the falling edge that sends the last result bit, with the result valid in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset |
| dclk | input | 1 | Serial and conversion clock |
| cs_n | input | 1 | Active-low chip select; high aborts |
| din | input | 1 | Serial command input, sampled on rising edges |
| comp | input | 1 | Comparator answer: input at or above dac_code |
| dout | output | 1 | Serial result output, updated on falling edges |
| dout_en | output | 1 | Output enable for dout (three-state control) |
| busy | output | 1 | One-clock hold marker |
| busy_en | output | 1 | Output enable for busy (three-state control) |
| track | output | 1 | High while the input is being acquired |
| dac_code | output | RES_W | Trial code presented to the comparator |
| done | output | 1 | One-clock strobe at the end of a conversion |
| result | output | RES_W | Parallel conversion result, valid with done |
| chan_sel | output | 3 | Selector field of the last complete command |
| single_ended | output | 1 | Reference flag of the last complete command |
| pd_mode | output | 2 | Power bits of the last complete command |

## Verification
Conversions are run on input codes at full scale, at zero, on either side of mid-scale and on an irregular pattern. These catch stuck trial bits, inverted comparator use and shifts by one bit in the serial stream. Frames are sent in 24-clock, 15-clock and 11-clock spacings. The short spacings show that overlapped commands are accepted at the exact earliest edge. Runs of ones placed just before that edge show that earlier start bits are refused. Aborts are placed both in mid-command and in mid-conversion. Together with high-select traffic, they separate a true abort from a result that was merely delayed, and show that a partial command cannot change the power bits.

// File: rtl/tsc_seq_pkg.sv
package tsc_seq_pkg;

    // Length of a command on the wire, start bit included
    localparam int WORD_W    = 8;
    // Clocks a frame needs beyond the resolved bit count
    localparam int FRAME_PAD = 3;
    // Receive count at which acquisition begins (falling edge of clock 5)
    localparam int ACQ_EDGE  = WORD_W - FRAME_PAD;
    localparam int CNT_W     = $clog2(WORD_W + 1);

    // Command payload after the start bit, first received bit at the top
    typedef struct packed {
        logic [2:0] chan;
        logic       mode8;
        logic       single;
        logic [1:0] pd;
    } ctrl_t;

    typedef enum logic {
        SAR_IDLE = 1'b0,
        SAR_RUN  = 1'b1
    } sar_phase_e;

    // Rising edges to skip after a command before a start bit counts
    function automatic int hold_len(input int res_bits);
        return res_bits + FRAME_PAD - WORD_W;
    endfunction

endpackage

// File: rtl/tsc_cmd_rx.sv
module tsc_cmd_rx
    import tsc_seq_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int LO_W  = 8
) (
    input  logic             dclk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             din,
    output logic             word_valid,
    output ctrl_t            cfg,
    output logic [CNT_W-1:0] bit_cnt
);

    localparam int SH_W      = WORD_W - 1;
    localparam int HOLD_HI_I = hold_len(RES_W);
    localparam int HOLD_LO_I = hold_len(LO_W);
    localparam int HOLD_W    = $clog2(HOLD_HI_I + 1);
    localparam logic [HOLD_W-1:0] HOLD_HI  = HOLD_W'(HOLD_HI_I);
    localparam logic [HOLD_W-1:0] HOLD_LO  = HOLD_W'(HOLD_LO_I);
    localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [HOLD_W-1:0] hold_q;
    logic [SH_W-1:0]   sh_q;
    logic [SH_W-1:0]   sh_nxt;
    ctrl_t             nxt_cfg;
    logic              wv_q;
    ctrl_t             cfg_q;

    assign sh_nxt  = {sh_q[SH_W-2:0], din};
    assign nxt_cfg = ctrl_t'(sh_nxt);

    always_ff @(posedge dclk) begin
        if (rst) begin
            cnt_q  <= '0;
            hold_q <= '0;
            sh_q   <= '0;
            wv_q   <= 1'b0;
            cfg_q  <= '0;
        end else if (cs_n) begin
            // deselect: drop any partial command, keep the last full one
            cnt_q  <= '0;
            hold_q <= '0;
            sh_q   <= '0;
            wv_q   <= 1'b0;
        end else begin
            wv_q <= 1'b0;
            if (cnt_q == '0) begin
                if (hold_q != '0) begin
                    hold_q <= hold_q - 1'b1;
                end else if (din) begin
                    cnt_q <= CNT_W'(1);
                end
            end else begin
                sh_q <= sh_nxt;
                if (cnt_q == LAST_CNT) begin
                    cnt_q  <= '0;
                    wv_q   <= 1'b1;
                    cfg_q  <= nxt_cfg;
                    hold_q <= nxt_cfg.mode8 ? HOLD_LO : HOLD_HI;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign word_valid = wv_q;
    assign cfg        = cfg_q;
    assign bit_cnt    = cnt_q;

    // R8: during the lock-out window no start bit is taken
    p_hold_blocks_start_r8: assert property (@(posedge dclk) disable iff (rst || cs_n)
        (cnt_q == '0 && hold_q != '0) |=> (cnt_q == '0));

    // R10: settings move only when a whole command has just landed
    p_cfg_on_full_word_r10: assert property (@(posedge dclk) disable iff (rst)
        !$stable(cfg_q) |-> wv_q);

    // R2: a completed command always leaves the receiver idle
    p_word_returns_idle_r2: assert property (@(posedge dclk) disable iff (rst || cs_n)
        wv_q |-> (cnt_q == '0));

endmodule

// File: rtl/tsc_sar_core.sv
module tsc_sar_core
    import tsc_seq_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int LO_W  = 8
) (
    input  logic             dclk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             word_valid,
    input  logic             mode8,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             comp,
    output logic             busy,
    output logic             dout,
    output logic             track,
    output logic             done,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result
);

    localparam int               DROP     = RES_W - LO_W;
    localparam logic [RES_W-1:0] MSB_MASK = {1'b1, {(RES_W-1){1'b0}}};
    localparam logic [RES_W-1:0] END_HI   = RES_W'(1);
    localparam logic [RES_W-1:0] END_LO   = RES_W'(1) << DROP;
    localparam logic [CNT_W-1:0] ACQ_CNT  = CNT_W'(ACQ_EDGE);

    sar_phase_e       phase_q;
    logic [RES_W-1:0] mask_q;
    logic [RES_W-1:0] code_q;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] kept;
    logic             m8_q;
    logic             busy_q;
    logic             dout_q;
    logic             track_q;
    logic             done_q;
    logic             last_bit;

    assign kept     = comp ? (code_q | mask_q) : code_q;
    assign last_bit = (mask_q == (m8_q ? END_LO : END_HI));

    always_ff @(negedge dclk) begin
        if (rst || cs_n) begin
            phase_q <= SAR_IDLE;
            mask_q  <= '0;
            code_q  <= '0;
            res_q   <= '0;
            m8_q    <= 1'b0;
            busy_q  <= 1'b0;
            dout_q  <= 1'b0;
            track_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            busy_q <= 1'b0;
            dout_q <= 1'b0;
            done_q <= 1'b0;
            if (bit_cnt == ACQ_CNT) begin
                track_q <= 1'b1;
            end
            if (word_valid) begin
                // hold instant: stop tracking, mark busy, arm first trial
                track_q <= 1'b0;
                busy_q  <= 1'b1;
                phase_q <= SAR_RUN;
                mask_q  <= MSB_MASK;
                code_q  <= '0;
                m8_q    <= mode8;
            end else if (phase_q == SAR_RUN) begin
                dout_q <= comp;
                code_q <= kept;
                mask_q <= mask_q >> 1;
                if (last_bit) begin
                    phase_q <= SAR_IDLE;
                    mask_q  <= '0;
                    done_q  <= 1'b1;
                    res_q   <= m8_q ? (kept >> DROP) : kept;
                end
            end
        end
    end

    assign dac_code = (phase_q == SAR_RUN) ? (code_q | mask_q) : '0;
    assign busy     = busy_q;
    assign dout     = dout_q;
    assign track    = track_q;
    assign done     = done_q;
    assign result   = res_q;

    // R4: the hold marker lasts one clock
    p_busy_one_clock_r4: assert property (@(negedge dclk) disable iff (rst || cs_n)
        busy_q |=> !busy_q);

    // R3: acquisition ends exactly where the hold marker begins
    p_track_into_hold_r3: assert property (@(negedge dclk) disable iff (rst || cs_n)
        $fell(track_q) |-> busy_q);

    // R6: only one trial bit is under test at a time
    p_trial_onehot_r6: assert property (@(negedge dclk) disable iff (rst)
        $onehot0(mask_q));

    // R11: the done strobe is a single clock wide
    p_done_single_r11: assert property (@(negedge dclk) disable iff (rst || cs_n)
        done_q |=> !done_q);

endmodule

// File: rtl/tsc_seq.sv
module tsc_seq
    import tsc_seq_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int LO_W  = 8
) (
    input  logic             rst,
    input  logic             dclk,
    input  logic             cs_n,
    input  logic             din,
    input  logic             comp,
    output logic             dout,
    output logic             dout_en,
    output logic             busy,
    output logic             busy_en,
    output logic             track,
    output logic [RES_W-1:0] dac_code,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic [2:0]       chan_sel,
    output logic             single_ended,
    output logic [1:0]       pd_mode
);

    logic             word_valid;
    ctrl_t            cfg;
    logic [CNT_W-1:0] bit_cnt;
    logic             busy_q;
    logic             dout_q;

    tsc_cmd_rx #(.RES_W(RES_W), .LO_W(LO_W)) u_rx (
        .dclk       (dclk),
        .rst        (rst),
        .cs_n       (cs_n),
        .din        (din),
        .word_valid (word_valid),
        .cfg        (cfg),
        .bit_cnt    (bit_cnt)
    );

    tsc_sar_core #(.RES_W(RES_W), .LO_W(LO_W)) u_sar (
        .dclk       (dclk),
        .rst        (rst),
        .cs_n       (cs_n),
        .word_valid (word_valid),
        .mode8      (cfg.mode8),
        .bit_cnt    (bit_cnt),
        .comp       (comp),
        .busy       (busy_q),
        .dout       (dout_q),
        .track      (track),
        .done       (done),
        .dac_code   (dac_code),
        .result     (result)
    );

    assign dout_en      = ~cs_n;
    assign busy_en      = ~cs_n;
    assign dout         = dout_q & ~cs_n;
    assign busy         = busy_q & ~cs_n;
    assign chan_sel     = cfg.chan;
    assign single_ended = cfg.single;
    assign pd_mode      = cfg.pd;

    // R9: deselect silences the converter on the following edge
    p_abort_quiet_r9: assert property (@(negedge dclk) disable iff (rst)
        cs_n |=> (!busy_q && !done));

    // R5: no data bit leaves during the hold marker
    p_dout_idle_at_hold_r5: assert property (@(negedge dclk) disable iff (rst || cs_n)
        busy_q |-> !dout_q);

endmodule

// File: tb/tsc_seq_tb.sv
module tsc_seq_tb;

    localparam int CLK_P = 10;
    localparam int NCYC  = 8192;

    logic        rst, dclk, cs_n, din;
    logic        comp;
    logic        dout, dout_en, busy, busy_en, track, done;
    logic [11:0] dac_code, result;
    logic [2:0]  chan_sel;
    logic        single_ended;
    logic [1:0]  pd_mode;

    logic [11:0] vin;
    logic        e_dout  [0:NCYC-1];
    logic        e_busy  [0:NCYC-1];
    logic        e_track [0:NCYC-1];
    logic [12:0] exp_q [$];
    int          cyc;
    int          n_chk;
    int          n_fail;
    logic [2:0]  cur_ch;
    logic        cur_se;
    logic [1:0]  cur_pd;

    tsc_seq u_dut (
        .rst          (rst),
        .dclk         (dclk),
        .cs_n         (cs_n),
        .din          (din),
        .comp         (comp),
        .dout         (dout),
        .dout_en      (dout_en),
        .busy         (busy),
        .busy_en      (busy_en),
        .track        (track),
        .dac_code     (dac_code),
        .done         (done),
        .result       (result),
        .chan_sel     (chan_sel),
        .single_ended (single_ended),
        .pd_mode      (pd_mode)
    );

    // ideal comparator model
    assign comp = (dac_code <= vin);

    initial dclk = 1'b0;
    always #(CLK_P/2) dclk = ~dclk;

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // one clock: drive din before the rising edge, sample after the falling edge
    task automatic step(input logic d);
        din = d;
        @(posedge dclk);
        @(negedge dclk);
        #1;
        cyc++;
        chk(dout  === e_dout[cyc],  "R5 dout",  int'(dout),  int'(e_dout[cyc]));
        chk(busy  === e_busy[cyc],  "R4 busy",  int'(busy),  int'(e_busy[cyc]));
        chk(track === e_track[cyc], "R3 track", int'(track), int'(e_track[cyc]));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic frame(input logic [2:0] ch, input logic m8, input logic se,
                         input logic [1:0] pd, input int len, input logic fill,
                         input int abort_at);
        logic [7:0]  w;
        logic [11:0] ev;
        int          rb;
        int          base;
        w    = {1'b1, ch, m8, se, pd};
        rb   = m8 ? 8 : 12;
        ev   = m8 ? {4'h0, vin[11:4]} : vin;
        base = cyc;
        for (int k = 5; k <= 7; k++) e_track[base + k] = 1'b1;
        e_busy[base + 8] = 1'b1;
        for (int i = 0; i < rb; i++) e_dout[base + 9 + i] = ev[rb - 1 - i];
        exp_q.push_back({m8, ev});
        for (int n = 1; n <= len; n++) begin
            if (n == abort_at) begin
                cs_n = 1'b1;
                for (int c = cyc + 1; c < NCYC; c++) begin
                    e_dout[c] = 1'b0; e_busy[c] = 1'b0; e_track[c] = 1'b0;
                end
                void'(exp_q.pop_back());
                step(1'b1);
                return;
            end
            step(n <= 8 ? w[8 - n] : fill);
            if (n == 7) begin
                chk(pd_mode == cur_pd,   "R2 pd early",   int'(pd_mode),  int'(cur_pd));
                chk(chan_sel == cur_ch,  "R2 chan early", int'(chan_sel), int'(cur_ch));
            end
            if (n == 8) begin
                cur_ch = ch; cur_se = se; cur_pd = pd;
                chk(chan_sel == ch,     "R2 chan",   int'(chan_sel),     int'(ch));
                chk(single_ended == se, "R2 single", int'(single_ended), int'(se));
                chk(pd_mode == pd,      "R2 pd",     int'(pd_mode),      int'(pd));
            end
        end
    endtask

    // scoreboard monitor
    initial begin
        logic [12:0] item;
        forever begin
            @(negedge dclk);
            #2;
            if (!rst && done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected done", 1, 0);
                end else begin
                    item = exp_q.pop_front();
                    if (item[12])
                        chk(result == item[11:0], "R7 result", int'(result), int'(item[11:0]));
                    else
                        chk(result == item[11:0], "R6 result", int'(result), int'(item[11:0]));
                end
            end
        end
    end

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog R11 actual=hang expected=finish");
        finish_run();
    end

    initial begin
        n_chk = 0; n_fail = 0; cyc = 0;
        cur_ch = '0; cur_se = 1'b0; cur_pd = '0;
        for (int c = 0; c < NCYC; c++) begin
            e_dout[c] = 1'b0; e_busy[c] = 1'b0; e_track[c] = 1'b0;
        end
        vin = '0; rst = 1'b1; cs_n = 1'b1; din = 1'b0;
        repeat (3) @(posedge dclk);
        rst = 1'b0;
        @(negedge dclk);
        #1;
        // reset state, deselected
        chk(dout_en == 1'b0, "R9 dout_en", int'(dout_en), 0);
        chk(busy_en == 1'b0, "R9 busy_en", int'(busy_en), 0);
        chk(pd_mode == 2'b00, "R2 reset pd", int'(pd_mode), 0);
        chk(done == 1'b0, "R11 reset done", int'(done), 0);
        cs_n = 1'b0;
        idle(6);                                           // R1 zeros start nothing
        chk(dout_en == 1'b1, "R9 enabled", int'(dout_en), 1);

        // 24-clock frames, 12-bit
        vin = 12'hA5C; frame(3'b001, 1'b0, 1'b1, 2'b11, 24, 1'b0, 0);
        vin = 12'hFFF; frame(3'b101, 1'b0, 1'b0, 2'b00, 24, 1'b0, 0);
        vin = 12'h000; frame(3'b011, 1'b0, 1'b1, 2'b01, 24, 1'b0, 0);
        vin = 12'h800; frame(3'b100, 1'b0, 1'b1, 2'b10, 24, 1'b0, 0);

        // R8 15-clock overlapped frames
        vin = 12'h7FF;
        frame(3'b001, 1'b0, 1'b0, 2'b11, 15, 1'b0, 0);
        frame(3'b101, 1'b0, 1'b0, 2'b11, 15, 1'b0, 0);
        frame(3'b001, 1'b0, 1'b0, 2'b01, 16, 1'b0, 0);
        idle(12);

        // R7 8-bit frames, R8 11-clock spacing
        vin = 12'h9C7;
        frame(3'b110, 1'b1, 1'b1, 2'b00, 11, 1'b0, 0);
        frame(3'b010, 1'b1, 1'b1, 2'b10, 11, 1'b0, 0);
        idle(12);

        // R8 early ones inside the lock-out window are refused
        vin = 12'h3A6;
        frame(3'b001, 1'b0, 1'b1, 2'b11, 15, 1'b1, 0);
        idle(12);
        frame(3'b001, 1'b1, 1'b1, 2'b01, 11, 1'b1, 0);
        idle(12);
        chk(exp_q.size() == 0, "R8 extra start", exp_q.size(), 0);

        // R9 abort mid-conversion
        vin = 12'h5A5;
        frame(3'b001, 1'b0, 1'b1, 2'b10, 24, 1'b0, 12);
        chk(dout_en == 1'b0, "R9 dout_en abort", int'(dout_en), 0);
        chk(busy_en == 1'b0, "R9 busy_en abort", int'(busy_en), 0);
        for (int i = 0; i < 10; i++) step(1'b1);            // R9 din ignored while deselected
        cs_n = 1'b0;
        idle(20);
        chk(exp_q.size() == 0, "R9 aborted result", exp_q.size(), 0);

        // R10 partial command cut by deselect
        frame(3'b111, 1'b0, 1'b0, 2'b00, 24, 1'b0, 5);
        chk(pd_mode == cur_pd, "R10 pd kept", int'(pd_mode), int'(cur_pd));
        chk(chan_sel == cur_ch, "R10 chan kept", int'(chan_sel), int'(cur_ch));
        chk(single_ended == cur_se, "R10 single kept", int'(single_ended), int'(cur_se));
        cs_n = 1'b0;
        idle(4);
        vin = 12'h123;
        frame(3'b101, 1'b0, 1'b0, 2'b00, 24, 1'b0, 0);
        idle(6);
        chk(exp_q.size() == 0, "R11 all results", exp_q.size(), 0);
        finish_run();
    end

endmodule